// File: doc/BRIEF.md
# Windowed Interrupt Priority Register Bank

This block stores one priority setting for each of 128 interrupt requests and lets software reach all of them through a narrow register interface. That interface has one group-select register and an eight-location data window. Software writes the group-select register to choose a run of eight consecutive interrupt vectors. The eight window locations then read and write the stored priorities of that run only.

Vectors sit two bytes apart. The group number in select bits [7:4] is therefore the upper nibble of the low byte of the first vector address in the run, and the register index is that nibble followed by the 3-bit window offset. Changing the selection only moves the view and never touches the stored values.

Every stored priority is also driven at all times on a flat output bus for a separate priority arbiter. That bus does not depend on which group is currently selected.

Top module: `irq_window_bank`

## Requirements
- R1: After reset every priority field equals the RESET_LEVEL parameter (default 1), the group-select register reads 0x00, and rdata is 0x00.
- R2: A write to offset 0 stores wdata[7:4] as the group number. A read of offset 0 returns the group number in bits [7:4] and zero in bits [3:0].
- R3: A write to window offset 8+k (k = 0..7) stores wdata[2:0] in request index {group, k}. Higher data bits are dropped, and the new value shows on prio_flat from the clock edge that accepts the write.
- R4: A read (cs=1, we=0) returns its data on rdata at the clock edge that accepts the access, so it is valid in the following cycle. A window read at offset 8+k returns the 3-bit priority of request {group, k} in bits [2:0] with bits [7:3] zero.
- R5: Writing the group-select register leaves all 128 stored priorities unchanged.
- R6: prio_flat bits [3i+2:3i] always carry the priority of request i, for every i from 0 to 127, whichever group is selected.
- R7: Offsets 1 to 7 are reserved. Writes to them change no state, and reads of them return 0x00.
- R8: A cycle with cs=0 changes no stored priority and no group selection, whatever we, addr and wdata carry.
- R9: rdata holds its last value in every cycle without a read access.
- R10: Writing 0xE0 to the group-select register makes window offsets 8 to 15 reach requests 112 to 119, in ascending order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs | input | 1 | Access strobe for the current cycle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 4 | Offset: 0 group select, 1-7 reserved, 8-15 window |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| prio_flat | output | 384 | Priority of request i at bits [3i+2:3i] |

## Verification
The assertions check, on every cycle, the rules that tie one access to the next cycle: a window write lands at the index formed from the current group and offset, and a window read returns that index's field. They also check that select readback keeps its low nibble at zero, that reserved offsets read as zero, that prio_flat stays frozen without a window write, and that rdata holds between reads. Only the bench's scenarios show the reset defaults and the 0xE0 group mapping onto requests 112 to 119. The scenarios also cover a full sweep that loads all 128 entries through every group, and the fact that entries hidden behind another selection still keep their values when the view comes back to them.

// File: rtl/irq_cfg_pkg.sv
package irq_cfg_pkg;

  // Kind of access decoded from the bus in the current cycle
  typedef enum logic [1:0] {
    ACC_IDLE = 2'd0,
    ACC_SEL  = 2'd1,
    ACC_WIN  = 2'd2,
    ACC_RSVD = 2'd3
  } acc_kind_e;

endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_core_n = chain_q[STAGES-1];

endmodule

// File: rtl/irq_bus_front.sv
module irq_bus_front
  import irq_cfg_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int GRP_W  = 4,
  parameter int OFF_W  = 3,
  localparam int IDX_W = GRP_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [GRP_W-1:0]  wr_group,
  output acc_kind_e         kind,
  output logic              win_wr,
  output logic              rd_en,
  output logic [IDX_W-1:0]  win_idx,
  output logic [GRP_W-1:0]  sel_q
);

  logic [GRP_W-1:0] sel_d;
  logic             sel_wr;

  // Address decode: top address bit opens the window, zero is the selector
  always_comb begin
    if (!cs)                       kind = ACC_IDLE;
    else if (addr == '0)           kind = ACC_SEL;
    else if (addr[ADDR_W-1])       kind = ACC_WIN;
    else                           kind = ACC_RSVD;
  end

  assign sel_wr  = (kind == ACC_SEL) && we;
  assign win_wr  = (kind == ACC_WIN) && we;
  assign rd_en   = cs && !we;
  assign win_idx = {sel_q, addr[OFF_W-1:0]};

  always_comb begin
    sel_d = sel_q;
    if (sel_wr) sel_d = wr_group;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= '0;
    else        sel_q <= sel_d;
  end

endmodule

// File: rtl/irq_prio_store.sv
module irq_prio_store #(
  parameter int NUM_REQ     = 128,
  parameter int PRIO_W      = 3,
  parameter int RESET_LEVEL = 1,
  localparam int IDX_W      = $clog2(NUM_REQ)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [IDX_W-1:0]          wr_idx,
  input  logic [PRIO_W-1:0]         wr_level,
  output logic [NUM_REQ*PRIO_W-1:0] prio_flat
);

  localparam logic [PRIO_W-1:0] RST_VAL = PRIO_W'(RESET_LEVEL);

  for (genvar g = 0; g < NUM_REQ; g++) begin : g_entry
    logic [PRIO_W-1:0] lvl_q;
    logic [PRIO_W-1:0] lvl_d;
    logic              hit;

    assign hit = wr_en && (wr_idx == IDX_W'(g));

    always_comb begin
      lvl_d = lvl_q;
      if (hit) lvl_d = wr_level;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= RST_VAL;
      else        lvl_q <= lvl_d;
    end

    assign prio_flat[g*PRIO_W +: PRIO_W] = lvl_q;
  end

endmodule

// File: rtl/irq_read_path.sv
module irq_read_path
  import irq_cfg_pkg::*;
#(
  parameter int NUM_REQ = 128,
  parameter int PRIO_W  = 3,
  parameter int DATA_W  = 8,
  parameter int GRP_W   = 4,
  localparam int IDX_W  = $clog2(NUM_REQ)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  acc_kind_e                 kind,
  input  logic                      rd_en,
  input  logic [IDX_W-1:0]          rd_idx,
  input  logic [GRP_W-1:0]          sel_q,
  input  logic [NUM_REQ*PRIO_W-1:0] prio_flat,
  output logic [DATA_W-1:0]         rdata
);

  logic [PRIO_W-1:0] fld;
  logic [DATA_W-1:0] rval;
  logic [DATA_W-1:0] rdata_d;

  assign fld = prio_flat[rd_idx*PRIO_W +: PRIO_W];

  always_comb begin
    unique case (kind)
      ACC_SEL: rval = {sel_q, {(DATA_W-GRP_W){1'b0}}};
      ACC_WIN: rval = {{(DATA_W-PRIO_W){1'b0}}, fld};
      default: rval = '0;
    endcase
  end

  always_comb begin
    rdata_d = rdata;
    if (rd_en) rdata_d = rval;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rdata_d;
  end

endmodule

// File: rtl/irq_window_bank.sv
module irq_window_bank
  import irq_cfg_pkg::*;
#(
  parameter int NUM_REQ     = 128,
  parameter int WIN_SIZE    = 8,
  parameter int PRIO_W      = 3,
  parameter int DATA_W      = 8,
  parameter int RESET_LEVEL = 1,
  localparam int OFF_W      = $clog2(WIN_SIZE),
  localparam int GRP_W      = $clog2(NUM_REQ / WIN_SIZE),
  localparam int IDX_W      = GRP_W + OFF_W,
  localparam int ADDR_W     = OFF_W + 1,
  localparam int FLAT_W     = NUM_REQ * PRIO_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [FLAT_W-1:0] prio_flat
);

  logic             rst_core_n;
  acc_kind_e        kind;
  logic             win_wr;
  logic             rd_en;
  logic [IDX_W-1:0] win_idx;
  logic [GRP_W-1:0] sel_q;
  logic             wdata_unused;

  // Bits between the priority field and the group field have no home
  assign wdata_unused = &{1'b0, wdata[DATA_W-GRP_W-1:PRIO_W]};

  irq_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  irq_bus_front #(
    .ADDR_W (ADDR_W),
    .GRP_W  (GRP_W),
    .OFF_W  (OFF_W)
  ) u_front (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .cs       (cs),
    .we       (we),
    .addr     (addr),
    .wr_group (wdata[DATA_W-1 -: GRP_W]),
    .kind     (kind),
    .win_wr   (win_wr),
    .rd_en    (rd_en),
    .win_idx  (win_idx),
    .sel_q    (sel_q)
  );

  irq_prio_store #(
    .NUM_REQ     (NUM_REQ),
    .PRIO_W      (PRIO_W),
    .RESET_LEVEL (RESET_LEVEL)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .wr_en     (win_wr),
    .wr_idx    (win_idx),
    .wr_level  (wdata[PRIO_W-1:0]),
    .prio_flat (prio_flat)
  );

  irq_read_path #(
    .NUM_REQ (NUM_REQ),
    .PRIO_W  (PRIO_W),
    .DATA_W  (DATA_W),
    .GRP_W   (GRP_W)
  ) u_read (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .kind      (kind),
    .rd_en     (rd_en),
    .rd_idx    (win_idx),
    .sel_q     (sel_q),
    .prio_flat (prio_flat),
    .rdata     (rdata)
  );

endmodule

// File: rtl/irq_window_bank_chk.sv
module irq_window_bank_chk #(
  parameter int NUM_REQ = 128,
  parameter int PRIO_W  = 3,
  parameter int DATA_W  = 8,
  parameter int GRP_W   = 4,
  parameter int OFF_W   = 3,
  localparam int IDX_W  = GRP_W + OFF_W,
  localparam int ADDR_W = OFF_W + 1
) (
  input logic                      clk,
  input logic                      rst_core_n,
  input logic                      cs,
  input logic                      we,
  input logic [ADDR_W-1:0]         addr,
  input logic [DATA_W-1:0]         wdata,
  input logic [DATA_W-1:0]         rdata,
  input logic [NUM_REQ*PRIO_W-1:0] prio_flat,
  input logic [GRP_W-1:0]          sel_q
);

  logic [IDX_W-1:0]  idx_now;
  logic [IDX_W-1:0]  idx_q;
  logic [PRIO_W-1:0] fld_now;
  logic [PRIO_W-1:0] fld_at_q;
  logic              win_acc;

  assign idx_now  = {sel_q, addr[OFF_W-1:0]};
  assign fld_now  = prio_flat[int'(idx_now)*PRIO_W +: PRIO_W];
  assign fld_at_q = prio_flat[int'(idx_q)*PRIO_W +: PRIO_W];
  assign win_acc  = cs && addr[ADDR_W-1];

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) idx_q <= '0;
    else             idx_q <= idx_now;
  end

  assert_window_write_R3: assert property (@(posedge clk) disable iff (!rst_core_n)
    (win_acc && we) |=> (fld_at_q == $past(wdata[PRIO_W-1:0])));

  assert_window_read_R4: assert property (@(posedge clk) disable iff (!rst_core_n)
    (win_acc && !we) |=> (rdata == {{(DATA_W-PRIO_W){1'b0}}, $past(fld_now)}));

  assert_select_readback_R2: assert property (@(posedge clk) disable iff (!rst_core_n)
    (cs && !we && addr == '0) |=>
      (rdata[DATA_W-GRP_W-1:0] == '0 && rdata[DATA_W-1 -: GRP_W] == $past(sel_q)));

  assert_reserved_read_R7: assert property (@(posedge clk) disable iff (!rst_core_n)
    (cs && !we && !addr[ADDR_W-1] && addr != '0) |=> (rdata == '0));

  assert_store_frozen_R5: assert property (@(posedge clk) disable iff (!rst_core_n)
    !(win_acc && we) |=> $stable(prio_flat));

  assert_select_idle_R8: assert property (@(posedge clk) disable iff (!rst_core_n)
    !cs |=> $stable(sel_q));

  assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (!rst_core_n)
    !(cs && !we) |=> $stable(rdata));

endmodule

bind irq_window_bank irq_window_bank_chk #(
  .NUM_REQ (NUM_REQ),
  .PRIO_W  (PRIO_W),
  .DATA_W  (DATA_W),
  .GRP_W   (GRP_W),
  .OFF_W   (OFF_W)
) u_chk (
  .clk        (clk),
  .rst_core_n (rst_core_n),
  .cs         (cs),
  .we         (we),
  .addr       (addr),
  .wdata      (wdata),
  .rdata      (rdata),
  .prio_flat  (prio_flat),
  .sel_q      (sel_q)
);

// File: tb/irq_window_bank_test.sv
module irq_window_bank_test;

  localparam int NREQ = 128;
  localparam int PW   = 3;
  localparam int FW   = NREQ * PW;

  logic          clk;
  logic          rst_n;
  logic          cs;
  logic          we;
  logic [3:0]    addr;
  logic [7:0]    wdata;
  logic [7:0]    rdata;
  logic [FW-1:0] prio_flat;

  irq_window_bank uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs        (cs),
    .we        (we),
    .addr      (addr),
    .wdata     (wdata),
    .rdata     (rdata),
    .prio_flat (prio_flat)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } sb_item_t;

  sb_item_t   sb_q[$];
  int         n_cmp  = 0;
  int         n_bad  = 0;
  bit         done   = 1'b0;
  logic [2:0] model[NREQ];
  logic [3:0] model_grp;
  logic [7:0] last_rd;

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic check8(string tag, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic check_flat(string tag);
    logic [FW-1:0] exp_flat;
    for (int i = 0; i < NREQ; i++) exp_flat[i*PW +: PW] = model[i];
    n_cmp++;
    if (prio_flat !== exp_flat) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, prio_flat, exp_flat);
    end
  endtask

  // Monitor: a read accepted at a rising edge is compared 2 ns later
  initial begin
    forever begin
      @(posedge clk);
      if (rst_n && cs && !we) begin
        #2;
        if (sb_q.size() == 0) begin
          n_cmp++; n_bad++;
          $display("FAIL scoreboard actual=%02h expected=none", rdata);
        end else begin
          sb_item_t it;
          it = sb_q.pop_front();
          check8(it.tag, rdata, it.exp);
          last_rd = rdata;
        end
      end
    end
  end

  task automatic bus_write(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    cs = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    cs = 1'b0; we = 1'b0;
    if (a == 4'd0) model_grp = d[7:4];
    else if (a[3]) model[{model_grp, a[2:0]}] = d[2:0];
  endtask

  task automatic bus_read(logic [3:0] a, string tag);
    sb_item_t it;
    if (a == 4'd0)  it.exp = {model_grp, 4'h0};
    else if (a[3])  it.exp = {5'b0, model[{model_grp, a[2:0]}]};
    else            it.exp = 8'h00;
    it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
    cs = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    cs = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    report();
  end

  initial begin
    cs = 1'b0; we = 1'b0; addr = '0; wdata = '0; rst_n = 1'b0;
    for (int i = 0; i < NREQ; i++) model[i] = 3'd1;
    model_grp = 4'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    check8("R1 rdata", rdata, 8'h00);
    check_flat("R1 defaults");
    bus_read(4'd0, "R1 select");

    // R2: low nibble of selector dropped
    bus_write(4'd0, 8'hE7);
    bus_read(4'd0, "R2 select readback");

    // R10 / R3: group 0xE reaches requests 112..119 in order
    bus_write(4'd0, 8'hE0);
    for (int k = 0; k < 8; k++) bus_write(4'(8 + k), 8'(7 - k));
    @(negedge clk);
    for (int k = 0; k < 8; k++)
      check8("R10 request map", {5'b0, prio_flat[(112 + k)*PW +: PW]}, 8'(7 - k));
    check_flat("R3 window writes");
    for (int k = 0; k < 8; k++) bus_read(4'(8 + k), "R4 window read");

    // R3: upper data bits dropped
    bus_write(4'd11, 8'hFD);
    bus_read(4'd11, "R3 field width");

    // R5 / R6: moving the view keeps contents, hidden entries still on bus
    bus_write(4'd0, 8'h30);
    @(negedge clk);
    check_flat("R5 select change");
    for (int k = 0; k < 8; k++) bus_read(4'(8 + k), "R6 other group");
    bus_write(4'd0, 8'hE0);
    bus_read(4'd8, "R5 revisit");

    // R7: reserved offsets
    bus_write(4'd3, 8'hFF);
    bus_write(4'd7, 8'h55);
    @(negedge clk);
    check_flat("R7 reserved write");
    bus_read(4'd0, "R7 select kept");
    bus_read(4'd5, "R7 reserved read");

    // R8: strobe low
    @(negedge clk);
    cs = 1'b0; we = 1'b1; addr = 4'd9; wdata = 8'h06;
    @(negedge clk);
    addr = 4'd0; wdata = 8'h90;
    @(negedge clk);
    we = 1'b0;
    check_flat("R8 idle write");
    bus_read(4'd0, "R8 select kept");

    // R9: rdata holds across idle cycles
    bus_read(4'd12, "R9 setup");
    repeat (4) @(negedge clk);
    check8("R9 hold", rdata, last_rd);

    // R6: sweep every entry through every group
    for (int g = 0; g < 16; g++) begin
      bus_write(4'd0, 8'(g << 4));
      for (int k = 0; k < 8; k++) bus_write(4'(8 + k), 8'(((g * 8 + k) * 3 + 1) & 7));
    end
    @(negedge clk);
    check_flat("R6 full sweep");
    bus_write(4'd0, 8'h20);
    for (int k = 0; k < 8; k++) bus_read(4'(8 + k), "R4 sweep read");
    bus_write(4'd0, 8'hF0);
    for (int k = 0; k < 8; k++) bus_read(4'(8 + k), "R4 sweep read top");

    repeat (3) @(negedge clk);
    if (sb_q.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL scoreboard actual=%0d expected=0 pending", sb_q.size());
    end
    report();
  end

endmodule